// File: doc/BRIEF.md
# I2C Bus-Hang Recovery Sequencer

This unit sits beside an I2C master and guards each transfer against a stuck bus. When `start_i` is accepted it begins counting toward a timeout. If `xfer_done_i` arrives first, the watch ends quietly. If the count runs out instead, `err_o` pulses for one cycle. If any one of the transfer-complete, bus-busy or received-NACK status flags is set at that moment, the unit also runs a recovery.

A recovery first pulses `al_clr_o`, which clears only the arbitration-lost status bit in the neighbouring status register. It then drives the two open-drain lines through a fixed train:

- an opening START;
- `CYCLES` clock periods, each with SCL held low for two unit delays and released for one unit delay, and a STOP followed by a START inside every released window;
- a closing STOP.

Any slave that is holding SDA low while it waits to finish a byte is therefore clocked out, even if it missed several clocks. SDA is never driven high, only released. The unit delay is derived from the bus-clock divider and has a lower clamp. A slave that stretches SCL pauses the train. `done_o` pulses once the closing STOP is complete, and the unit is idle again.

Top module: `i2c_hang_recover`

## Requirements
- R1: Timeout length. `err_o` is a one-cycle pulse exactly L cycles after the clock edge that accepts `start_i`, unless `xfer_done_i` arrives first. L is latched when `start_i` is accepted and is chosen as follows:
  - if `timeout_i` is 0, L = `DEF_TO`;
  - if `timeout_i` is between 1 and `MIN_TO`-1, L = `MIN_TO`;
  - otherwise L = `timeout_i`.
- R2: `xfer_done_i` high before the timeout ends the watch. No `err_o`, no `al_clr_o` and no bus activity follow.
- R3: A recovery runs only if at least one of `flag_cf_i`, `flag_bb_i` or `flag_nack_i` is high in the cycle the timeout expires. If all three are low, the unit returns to idle and never pulls SCL or SDA low. An output of 1 on `scl_oe_o` or `sda_oe_o` means the line is pulled low; 0 means it is released.
- R4: When a recovery runs, `al_clr_o` is high for exactly one cycle. That cycle is the same cycle as `err_o`, and both lines are still released in it.
- R5: The unit delay in clock cycles is UC = max(2, (D >> `SCALE_SH`) + 1) << `STEP_SH`. D is `clk_div_i`, or `DEF_DIV` when `clk_div_i` is 0. D is latched at the timeout.
- R6: A recovery produces exactly `CYCLES` SCL-low pulses of 2·UC cycles each, followed by one final SCL-low pulse of UC cycles.
- R7: SDA changes only while SCL is released in both the current and the previous cycle. A recovery contains `CYCLES`+1 START events (SDA pulled low while SCL is released) and `CYCLES`+1 STOP events (SDA released while SCL is released).
- R8: `done_o` is a one-cycle pulse 1 + UC·(3·`CYCLES`+3) cycles after `err_o`, provided SCL is never stretched. When it occurs both lines are released.
- R9: In a phase where SCL is released, a low `scl_i` freezes the sequencer. Each stretched cycle delays `done_o` by one cycle and leaves the pulse lengths unchanged.
- R10: `start_i` is ignored while the unit is watching or recovering.
- R11: While and after reset, with no stimulus, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin watching a transfer |
| xfer_done_i | input | 1 | Transfer finished normally |
| flag_cf_i | input | 1 | Transfer-complete status flag |
| flag_bb_i | input | 1 | Bus-busy status flag |
| flag_nack_i | input | 1 | Received-NACK status flag |
| timeout_i | input | TO_W | Timeout in cycles (0 selects the default) |
| clk_div_i | input | DIV_W | Bus clock divider (0 selects the default) |
| scl_i | input | 1 | Sampled SCL line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| al_clr_o | output | 1 | Clear the arbitration-lost status bit |
| err_o | output | 1 | Timeout error pulse |
| done_o | output | 1 | Recovery finished pulse |

## Verification
The bench builds the unit with an 8-bit divider, `SCALE_SH`=2, `STEP_SH`=1 and `DEF_DIV`=16, and with an 8-bit timeout, `DEF_TO`=40 and `MIN_TO`=5. These values put the default divider and the clamp of the unit delay to 2 within reach; so are the default timeout and its clamp, each within a few dozen cycles. They also let the bench sweep every one of the seven non-empty flag combinations against several dividers, up to the largest divider of 255, whose train lasts several thousand cycles. Under this configuration the bench computes the exact pulse counts, pulse lengths and `done_o` cycle for each case, including cases with SCL stretching.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_WATCH, PH_CLR, PH_PRE, PH_LOW, PH_HIGH, PH_FLO, PH_FHI, PH_DONE
  } phase_e;
endpackage

// File: rtl/i2c_rcv_limits.sv
module i2c_rcv_limits #(
  parameter int TO_W     = 32,
  parameter int DIV_W    = 16,
  parameter int DEF_TO   = 100_000_000,
  parameter int MIN_TO   = 5,
  parameter int DEF_DIV  = 2048,
  parameter int SCALE_SH = 4,
  parameter int STEP_SH  = 1,
  parameter int UC_W     = DIV_W + STEP_SH + 1
) (
  input  logic [TO_W-1:0]  timeout_i,
  input  logic [DIV_W-1:0] clk_div_i,
  output logic [TO_W-1:0]  to_lim_o,
  output logic [UC_W-1:0]  uc_o
);
  localparam logic [TO_W-1:0]  DEF_TO_V  = TO_W'(DEF_TO);
  localparam logic [TO_W-1:0]  MIN_TO_V  = TO_W'(MIN_TO);
  localparam logic [DIV_W-1:0] DEF_DIV_V = DIV_W'(DEF_DIV);

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W:0]   unit;

  always_comb begin
    if (timeout_i == '0)          to_lim_o = DEF_TO_V;
    else if (timeout_i < MIN_TO_V) to_lim_o = MIN_TO_V;
    else                           to_lim_o = timeout_i;
  end

  always_comb begin
    div_eff = (clk_div_i == '0) ? DEF_DIV_V : clk_div_i;
    unit    = {1'b0, div_eff >> SCALE_SH} + 1'b1;
    if (unit < 2) unit = 2;
    uc_o    = UC_W'(unit) << STEP_SH;
  end
endmodule

// File: rtl/i2c_rcv_wave.sv
module i2c_rcv_wave
  import i2c_rcv_pkg::*;
#(
  parameter int UC_W = 10,
  parameter int PC_W = UC_W + 1
) (
  input  phase_e          ph_i,
  input  logic [PC_W-1:0] cnt_i,
  input  logic [UC_W-1:0] uc_i,
  output logic            scl_oe_o,
  output logic            sda_oe_o
);
  logic [PC_W-1:0] q1, q2;

  // STOP at a quarter of the released window, START at half
  assign q1 = PC_W'(uc_i >> 2);
  assign q2 = q1 << 1;

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (ph_i)
      PH_PRE:  sda_oe_o = 1'b1;
      PH_LOW, PH_FLO: begin
        scl_oe_o = 1'b1;
        sda_oe_o = 1'b1;
      end
      PH_HIGH: sda_oe_o = (cnt_i < q1) || (cnt_i >= q2);
      PH_FHI:  sda_oe_o = (cnt_i < q1);
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_hang_recover.sv
module i2c_hang_recover
  import i2c_rcv_pkg::*;
#(
  parameter int TO_W     = 32,
  parameter int DIV_W    = 16,
  parameter int DEF_TO   = 100_000_000,
  parameter int MIN_TO   = 5,
  parameter int DEF_DIV  = 2048,
  parameter int SCALE_SH = 4,
  parameter int STEP_SH  = 1,
  parameter int CYCLES   = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             xfer_done_i,
  input  logic             flag_cf_i,
  input  logic             flag_bb_i,
  input  logic             flag_nack_i,
  input  logic [TO_W-1:0]  timeout_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic             scl_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             al_clr_o,
  output logic             err_o,
  output logic             done_o
);
  localparam int UC_W = DIV_W + STEP_SH + 1;
  localparam int PC_W = UC_W + 1;
  localparam int CY_W = $clog2(CYCLES + 1);
  localparam logic [CY_W-1:0] CY_LAST = CY_W'(CYCLES - 1);

  phase_e          ph_q;
  logic [TO_W-1:0] to_cnt_q, to_lim_q, to_lim;
  logic [UC_W-1:0] uc_q, uc_d;
  logic [PC_W-1:0] cnt_q, ph_len;
  logic [CY_W-1:0] cyc_q;
  logic            err_q, rel, adv, last, stuck;

  i2c_rcv_limits #(
    .TO_W(TO_W), .DIV_W(DIV_W), .DEF_TO(DEF_TO), .MIN_TO(MIN_TO),
    .DEF_DIV(DEF_DIV), .SCALE_SH(SCALE_SH), .STEP_SH(STEP_SH), .UC_W(UC_W)
  ) u_limits (
    .timeout_i(timeout_i), .clk_div_i(clk_div_i),
    .to_lim_o(to_lim), .uc_o(uc_d)
  );

  i2c_rcv_wave #(.UC_W(UC_W), .PC_W(PC_W)) u_wave (
    .ph_i(ph_q), .cnt_i(cnt_q), .uc_i(uc_q),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
  );

  assign stuck  = flag_cf_i | flag_bb_i | flag_nack_i;
  assign rel    = (ph_q == PH_PRE) || (ph_q == PH_HIGH) || (ph_q == PH_FHI);
  assign adv    = !rel || scl_i;  // slave clock stretching holds timing
  assign ph_len = (ph_q == PH_LOW) ? {uc_q, 1'b0} : PC_W'(uc_q);
  assign last   = adv && (cnt_q == ph_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      to_cnt_q <= '0;
      to_lim_q <= '0;
      uc_q     <= '0;
      cnt_q    <= '0;
      cyc_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q     <= PH_WATCH;
          to_cnt_q <= '0;
          to_lim_q <= to_lim;
        end
        PH_WATCH: begin
          if (xfer_done_i) ph_q <= PH_IDLE;
          else if (to_cnt_q == to_lim_q - 1'b1) begin
            err_q <= 1'b1;
            uc_q  <= uc_d;
            ph_q  <= stuck ? PH_CLR : PH_IDLE;
          end else to_cnt_q <= to_cnt_q + 1'b1;
        end
        PH_CLR: begin
          ph_q  <= PH_PRE;
          cnt_q <= '0;
        end
        PH_PRE, PH_LOW, PH_HIGH, PH_FLO, PH_FHI: if (adv) begin
          if (!last) cnt_q <= cnt_q + 1'b1;
          else begin
            cnt_q <= '0;
            unique case (ph_q)
              PH_PRE: begin
                ph_q  <= PH_LOW;
                cyc_q <= '0;
              end
              PH_LOW:  ph_q <= PH_HIGH;
              PH_HIGH: begin
                if (cyc_q == CY_LAST) ph_q <= PH_FLO;
                else begin
                  cyc_q <= cyc_q + 1'b1;
                  ph_q  <= PH_LOW;
                end
              end
              PH_FLO:  ph_q <= PH_FHI;
              default: ph_q <= PH_DONE;
            endcase
          end
        end
        PH_DONE: ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign al_clr_o = (ph_q == PH_CLR);
  assign err_o    = err_q;
  assign done_o   = (ph_q == PH_DONE);

  // checker: SCL-low run length
  logic [PC_W-1:0] scl_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       scl_len_q <= '0;
    else if (scl_oe_o) scl_len_q <= scl_len_q + 1'b1;
    else               scl_len_q <= '0;
  end

  assert_quiet_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_IDLE || ph_q == PH_WATCH) |-> (!scl_oe_o && !sda_oe_o));
  assert_al_before_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_clr_o |-> (err_o && !scl_oe_o && !sda_oe_o));
  assert_scl_low_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> (scl_len_q == {uc_q, 1'b0} || scl_len_q == PC_W'(uc_q)));
  assert_cycle_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q <= CY_LAST);
  assert_sda_moves_scl_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> (!scl_oe_o && !$past(scl_oe_o)));
  assert_done_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !scl_oe_o && !sda_oe_o));
  assert_err_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  assert_stretch_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel && !scl_i) |=> ($stable(cnt_q) && $stable(ph_q)));
endmodule

// File: tb/i2c_hang_recover_tb.sv
module i2c_hang_recover_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO_W = 8, DIV_W = 8, DEF_TO = 40, MIN_TO = 5;
  localparam int DEF_DIV = 16, SCALE_SH = 2, STEP_SH = 1, CYCLES = 9;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, xfer_done_i = 1'b0;
  logic flag_cf_i = 1'b0, flag_bb_i = 1'b0, flag_nack_i = 1'b0, hold_low = 1'b0;
  logic [TO_W-1:0]  timeout_i = '0;
  logic [DIV_W-1:0] clk_div_i = '0;
  logic scl_i, scl_oe_o, sda_oe_o, al_clr_o, err_o, done_o;

  assign scl_i = !scl_oe_o && !hold_low;

  i2c_hang_recover #(
    .TO_W(TO_W), .DIV_W(DIV_W), .DEF_TO(DEF_TO), .MIN_TO(MIN_TO),
    .DEF_DIV(DEF_DIV), .SCALE_SH(SCALE_SH), .STEP_SH(STEP_SH), .CYCLES(CYCLES)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .xfer_done_i(xfer_done_i),
    .flag_cf_i(flag_cf_i), .flag_bb_i(flag_bb_i), .flag_nack_i(flag_nack_i),
    .timeout_i(timeout_i), .clk_div_i(clk_div_i), .scl_i(scl_i),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .al_clr_o(al_clr_o),
    .err_o(err_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int n_err, n_al, n_done, n_long, n_short, n_bad, n_start, n_stop;
  int t_err, t_al, t_done, run_len = 0, hold_left = 0, stretch_req = 0, cur_uc = 4;
  logic p_scl = 1'b0, p_sda = 1'b0;

  always @(negedge clk_i) begin
    if (err_o) begin n_err++; t_err = cyc; end
    if (al_clr_o) begin
      n_al++; t_al = cyc;
      if (scl_oe_o || sda_oe_o) n_bad++;
    end
    if (done_o) begin n_done++; t_done = cyc; end
    if (scl_oe_o) run_len++;
    else if (p_scl) begin
      if (run_len == 2*cur_uc) begin
        n_long++;
        if (n_long == 1 && stretch_req > 0) hold_left = stretch_req;
      end else if (run_len == cur_uc) n_short++;
      else n_bad++;
      run_len = 0;
    end
    if (sda_oe_o && !p_sda && !scl_oe_o && !p_scl) n_start++;
    if (!sda_oe_o && p_sda && !scl_oe_o && !p_scl) n_stop++;
    if ((sda_oe_o != p_sda) && (scl_oe_o || p_scl)) n_bad++;
    hold_low = (hold_left > 0);
    if (hold_left > 0) hold_left--;
    p_scl = scl_oe_o;
    p_sda = sda_oe_o;
  end

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lim(input int t);
    if (t == 0) return DEF_TO;
    if (t < MIN_TO) return MIN_TO;
    return t;
  endfunction

  function automatic int exp_uc(input int d);
    int de, u;
    de = (d == 0) ? DEF_DIV : d;
    u  = (de >> SCALE_SH) + 1;
    if (u < 2) u = 2;
    return u << STEP_SH;
  endfunction

  task automatic clear_mon();
    n_err = 0; n_al = 0; n_done = 0; n_long = 0; n_short = 0; n_bad = 0;
    n_start = 0; n_stop = 0; t_err = -1; t_al = -1; t_done = -1;
  endtask

  // re_at: step index at which start_i is pulsed again (-1: never)
  task automatic run_case(input int to, input int div, input int f, input int s, input int re_at);
    int lim, uc, t_start, total, dur;
    lim = exp_lim(to);
    uc  = exp_uc(div);
    dur = 1 + uc*(3*CYCLES + 3) + s;
    clear_mon();
    cur_uc = uc;
    stretch_req = s;
    timeout_i = TO_W'(to);
    clk_div_i = DIV_W'(div);
    {flag_cf_i, flag_bb_i, flag_nack_i} = 3'(f);
    start_i = 1'b1;
    t_start = cyc + 1;
    step();
    start_i = 1'b0;
    total = lim + ((f != 0) ? dur : 0) + 5;
    for (int i = 0; i < total; i++) begin
      start_i = (i == re_at);
      step();
    end
    start_i = 1'b0;
    chk(n_err == 1 && t_err - t_start == lim, "R1 timeout", t_err - t_start, lim);
    if (f == 0) begin
      chk(n_al == 0 && n_done == 0 && n_long + n_short == 0, "R3 no recovery",
          n_al + n_done + n_long + n_short, 0);
    end else begin
      chk(n_al == 1 && t_al == t_err, "R4 al clear", t_al, t_err);
      chk(n_long == CYCLES && n_bad == 0, "R6 long pulses (R5 unit)", n_long, CYCLES);
      chk(n_short == 1, "R6 final pulse", n_short, 1);
      chk(n_start == CYCLES + 1 && n_stop == CYCLES + 1, "R7 start/stop", n_start*100 + n_stop,
          (CYCLES + 1)*101);
      chk(n_done == 1 && t_done - t_err == dur, "R8 R9 done timing", t_done - t_err, dur);
    end
    chk(!scl_oe_o && !sda_oe_o, "R8 lines released", {scl_oe_o, sda_oe_o}, 0);
    {flag_cf_i, flag_bb_i, flag_nack_i} = 3'b000;
    repeat (3) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) step();
    chk({scl_oe_o, sda_oe_o, al_clr_o, err_o, done_o} == 5'b0, "R11 in reset",
        {scl_oe_o, sda_oe_o, al_clr_o, err_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (3) step();
    chk({scl_oe_o, sda_oe_o, al_clr_o, err_o, done_o} == 5'b0, "R11 after reset",
        {scl_oe_o, sda_oe_o, al_clr_o, err_o, done_o}, 0);

    // R1 R3: timeout sweep, no flags
    for (int t = 0; t <= 12; t++) run_case(t, 0, 0, 0, -1);
    // R3-R8: every flag combination against several dividers
    for (int f = 1; f < 8; f++) begin
      run_case(12, 0, f, 0, -1);
      run_case(12, 3, f, 0, -1);
      run_case(5, 4, f, 0, -1);
      run_case(7, 8, f, 0, -1);
      run_case(20, 255, f, 0, -1);
    end
    // R9: SCL stretching
    run_case(6, 8, 2, 1, -1);
    run_case(6, 8, 4, 5, -1);
    // R10: start ignored while watching and while recovering
    run_case(10, 0, 0, 0, 4);
    run_case(10, 3, 1, 0, 40);

    // R2: normal completion before timeout
    clear_mon();
    timeout_i = 8'd10;
    flag_bb_i = 1'b1;
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    repeat (3) step();
    xfer_done_i = 1'b1;
    step();
    xfer_done_i = 1'b0;
    repeat (30) step();
    chk(n_err == 0 && n_al == 0 && n_long + n_short == 0, "R2 completed transfer",
        n_err + n_al + n_long + n_short, 0);
    flag_bb_i = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule